// File: doc/BRIEF.md
# Speculative loop iteration launcher

This block runs a counting loop whose exit test is slow. Each iteration proposes a candidate value of the loop variable x, starting from zero. The exit test compares the candidate against a bound, and its verdict emerges from a fixed-latency pipeline `TEST_LAT` cycles later. The loop body's single side effect is to advance a committed copy of x by one.

To keep the loop moving while verdicts are still in flight, the launcher may issue up to `SPEC_DEPTH` iterations ahead of their exit results. The spacing between issues is fixed when the block is built, and it is chosen so that the speculation window covers the test latency. When the first verdict that says "stop" comes back, the launcher stops issuing. Verdicts for iterations beyond that point are thrown away. The block then waits until the pipeline is empty, pulses `done` and presents the final x.

A caller offers a bound on `start_bound` together with `start_valid`. The request is taken only while `start_ready` is high. The answer appears on `result` when `done` pulses.

Top module: `spec_loop_launcher`

## Requirements
- R1: Issue interval. The interval between consecutive iteration issues is `TEST_LAT` when `SPEC_DEPTH` = 0. Otherwise it is the larger of 1 and ceil(`TEST_LAT` / `SPEC_DEPTH`). For a latency of 39, this gives 39, 4 and 1 for depths 0, 10 and 50.
- R2: Outstanding limit. The number of issued iterations whose exit verdict has not yet returned never exceeds `SPEC_DEPTH`. A depth of 0 counts as a limit of 1.
- R3: Squashing. The committed x advances only when a returning verdict says "continue" and no exit has yet been found. Verdicts arriving after the exit leave no trace.
- R4: Result value. For a bound b, the final result equals b, so a bound of 0 ends on the very first iteration with result 0.
- R5: Done pulse. `done` is high for exactly one cycle. It rises only once every real and speculative iteration has left the exit pipeline.
- R6: Start handling. A start is taken only while `start_ready` is high, and `start_ready` is low from the cycle after a start until `done`. A request offered while the launcher is busy changes neither the running job's result nor its timing.
- R7: Result hold. `result` changes only at the edge where `done` rises. It keeps its value while idle and through the next job, until that job's `done`.
- R8: Job timing. Let the start be taken at clock edge s, let I be the interval from R1, and let T be the number of k ≥ 0 with k·I < `TEST_LAT`. Then `done` is first seen high after edge s + 2 + (b + T − 1)·I + `TEST_LAT`.
- R9: No issue after exit. Once an exit verdict has been seen, no further iteration is issued for that job.
- R10: Reset state. After reset, `done` is 0, `start_ready` is 1 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request to run the loop |
| start_ready | output | 1 | Launcher idle, request will be taken |
| start_bound | input | WIDTH | Bound the candidate value is compared against |
| done | output | 1 | One-cycle pulse when the job has fully drained |
| result | output | WIDTH | Final value of x, held until the next done |

## Verification
Several properties are checked on every cycle:
- issues are never closer than the interval;
- the in-flight count stays under the limit and agrees with the pipeline's occupancy;
- no commit carries a value at or above the bound;
- nothing issues after an exit;
- done is a drained single-cycle pulse;
- the bound and result stay stable outside their update points.

Other behaviour can only be shown by the bench's scenarios: the exact result, the total job latency for several depths (which shows the speculative tail being issued and then squashed), and the fact that a request offered while busy leaves a running job untouched.

// File: rtl/sll_pkg.sv
package sll_pkg;

  // Issue interval: full test latency without speculation, otherwise the
  // smallest spacing whose speculation window covers the latency.
  function automatic int calc_ii(input int depth, input int lat);
    int q;
    if (depth == 0) return lat;
    q = (lat + depth - 1) / depth;
    return (q < 1) ? 1 : q;
  endfunction

  // Number of iterations allowed in flight.
  function automatic int calc_cap(input int depth);
    return (depth == 0) ? 1 : depth;
  endfunction

  function automatic int cnt_w(input int depth);
    return $clog2(calc_cap(depth) + 1);
  endfunction

  function automatic int gap_w(input int depth, input int lat);
    return $clog2(calc_ii(depth, lat) + 1);
  endfunction

endpackage

// File: rtl/sll_issue_ctrl.sv
module sll_issue_ctrl #(
  parameter int SPEC_DEPTH = 10,
  parameter int TEST_LAT   = 39,
  localparam int CW        = sll_pkg::cnt_w(SPEC_DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          enable,
  input  logic          ret,
  output logic          issue,
  output logic [CW-1:0] outstanding
);
  localparam int II = sll_pkg::calc_ii(SPEC_DEPTH, TEST_LAT);
  localparam int CAP = sll_pkg::calc_cap(SPEC_DEPTH);
  localparam int GW = sll_pkg::gap_w(SPEC_DEPTH, TEST_LAT);
  localparam logic [CW-1:0] CAP_V = CW'(CAP);
  localparam logic [GW-1:0] RELOAD = GW'(II - 1);

  logic [GW-1:0] gap;
  logic          room;

  // a returning verdict frees its slot in the same cycle
  assign room  = (outstanding < CAP_V) || ret;
  assign issue = enable && (gap == '0) && room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap         <= '0;
      outstanding <= '0;
    end else begin
      outstanding <= outstanding + CW'(issue) - CW'(ret);
      if (clear)              gap <= '0;
      else if (issue)         gap <= RELOAD;
      else if (gap != '0)     gap <= gap - 1'b1;
    end
  end
endmodule

// File: rtl/sll_exit_pipe.sv
module sll_exit_pipe #(
  parameter int WIDTH    = 16,
  parameter int TEST_LAT = 39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_val,
  input  logic             in_hit,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_val,
  output logic             out_hit,
  output logic             empty
);
  logic [TEST_LAT-1:0] vld;
  logic [TEST_LAT-1:0] hit;
  logic [WIDTH-1:0]    val [TEST_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      hit <= '0;
      for (int i = 0; i < TEST_LAT; i++) val[i] <= '0;
    end else begin
      for (int i = TEST_LAT - 1; i > 0; i--) begin
        vld[i] <= vld[i-1];
        hit[i] <= hit[i-1];
        val[i] <= val[i-1];
      end
      vld[0] <= in_vld;
      hit[0] <= in_hit;
      val[0] <= in_val;
    end
  end

  assign out_vld = vld[TEST_LAT-1];
  assign out_hit = hit[TEST_LAT-1];
  assign out_val = val[TEST_LAT-1];
  assign empty   = (vld == '0);
endmodule

// File: rtl/sll_commit.sv
module sll_commit #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ret_vld,
  input  logic [WIDTH-1:0] ret_val,
  input  logic             ret_hit,
  output logic             exit_seen,
  output logic             exit_now,
  output logic             commit,
  output logic             squash,
  output logic [WIDTH-1:0] x_commit
);
  assign exit_now = ret_vld && ret_hit && !exit_seen;
  assign commit   = ret_vld && !ret_hit && !exit_seen;
  assign squash   = ret_vld && exit_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exit_seen <= 1'b0;
      x_commit  <= '0;
    end else if (clear) begin
      exit_seen <= 1'b0;
      x_commit  <= '0;
    end else begin
      if (exit_now) exit_seen <= 1'b1;
      if (commit)   x_commit  <= ret_val + 1'b1;
    end
  end
endmodule

// File: rtl/spec_loop_launcher.sv
module spec_loop_launcher #(
  parameter int SPEC_DEPTH = 10,
  parameter int TEST_LAT   = 39,
  parameter int WIDTH      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [WIDTH-1:0] start_bound,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  localparam int CW = sll_pkg::cnt_w(SPEC_DEPTH);

  logic             busy;
  logic [WIDTH-1:0] bound_q;
  logic [WIDTH-1:0] issue_x;
  logic             start_fire, enable, issue, finish;
  logic [CW-1:0]    outstanding;
  logic             ret_vld, ret_hit, pipe_empty;
  logic [WIDTH-1:0] ret_val;
  logic             exit_seen, exit_now, commit, squash;
  logic [WIDTH-1:0] x_commit;

  assign start_ready = !busy;
  assign start_fire  = start_valid && !busy;
  assign enable      = busy && !exit_seen && !exit_now;
  assign finish      = busy && exit_seen && pipe_empty && (outstanding == '0);

  sll_issue_ctrl #(.SPEC_DEPTH(SPEC_DEPTH), .TEST_LAT(TEST_LAT)) u_issue (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .enable(enable),
    .ret(ret_vld), .issue(issue), .outstanding(outstanding)
  );

  sll_exit_pipe #(.WIDTH(WIDTH), .TEST_LAT(TEST_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .in_vld(issue), .in_val(issue_x),
    .in_hit(issue_x >= bound_q), .out_vld(ret_vld), .out_val(ret_val),
    .out_hit(ret_hit), .empty(pipe_empty)
  );

  sll_commit #(.WIDTH(WIDTH)) u_commit (
    .clk(clk), .rst_n(rst_n), .clear(start_fire), .ret_vld(ret_vld),
    .ret_val(ret_val), .ret_hit(ret_hit), .exit_seen(exit_seen),
    .exit_now(exit_now), .commit(commit), .squash(squash), .x_commit(x_commit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bound_q <= '0;
      issue_x <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= finish;
      if (start_fire) begin
        busy    <= 1'b1;
        bound_q <= start_bound;
        issue_x <= '0;
      end else begin
        if (issue)  issue_x <= issue_x + 1'b1;
        if (finish) begin
          busy   <= 1'b0;
          result <= x_commit;
        end
      end
    end
  end
endmodule

// File: rtl/spec_loop_launcher_chk.sv
module spec_loop_launcher_chk #(
  parameter int SPEC_DEPTH = 10,
  parameter int TEST_LAT   = 39,
  parameter int WIDTH      = 16,
  localparam int CW        = sll_pkg::cnt_w(SPEC_DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue,
  input logic [CW-1:0]    outstanding,
  input logic             pipe_empty,
  input logic             commit,
  input logic [WIDTH-1:0] ret_val,
  input logic             exit_seen,
  input logic             finish,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] bound_q,
  input logic [WIDTH-1:0] result
);
  localparam int II = sll_pkg::calc_ii(SPEC_DEPTH, TEST_LAT);
  localparam int CAP = sll_pkg::calc_cap(SPEC_DEPTH);
  localparam int GW = sll_pkg::gap_w(SPEC_DEPTH, TEST_LAT);
  localparam logic [GW-1:0] II_V = GW'(II);

  // cycles since the last issue, saturating at the interval
  logic [GW-1:0] since;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           since <= II_V;
    else if (issue)       since <= GW'(1);
    else if (since < II_V) since <= since + 1'b1;
  end

  AST_ISSUE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> since >= II_V);                                  // R1
  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) <= CAP);                                  // R2
  AST_COUNT_MATCHES_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (outstanding == '0) == pipe_empty);                        // R2
  AST_COMMIT_BELOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ret_val < bound_q);                             // R3
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pipe_empty && !busy);                             // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                           // R5
  AST_BOUND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(bound_q));                                // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(result));                              // R7
  AST_NO_ISSUE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    exit_seen |-> !issue);                                     // R9
endmodule

bind spec_loop_launcher spec_loop_launcher_chk #(
  .SPEC_DEPTH(SPEC_DEPTH), .TEST_LAT(TEST_LAT), .WIDTH(WIDTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .outstanding(outstanding),
  .pipe_empty(pipe_empty), .commit(commit), .ret_val(ret_val),
  .exit_seen(exit_seen), .finish(finish), .busy(busy), .done(done),
  .bound_q(bound_q), .result(result)
);

// File: tb/spec_loop_launcher_bench.sv
`timescale 1ns/1ps
module spec_loop_launcher_bench;
  localparam int W = 16;
  localparam int LAT = 39;
  localparam int NI = 3;
  localparam int DEPTHS [NI] = '{10, 0, 50};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_valid = 1'b0;
  logic [W-1:0] start_bound = '0;
  logic [NI-1:0] ready_w, done_w;
  logic [W-1:0] res_w [NI];
  logic [W-1:0] prev [NI];
  int total = 0;
  int bad = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  spec_loop_launcher #(.SPEC_DEPTH(10), .TEST_LAT(LAT), .WIDTH(W)) u_spec_loop_launcher (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(ready_w[0]),
    .start_bound(start_bound), .done(done_w[0]), .result(res_w[0]));
  spec_loop_launcher #(.SPEC_DEPTH(0), .TEST_LAT(LAT), .WIDTH(W)) u_spec_loop_launcher_n0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(ready_w[1]),
    .start_bound(start_bound), .done(done_w[1]), .result(res_w[1]));
  spec_loop_launcher #(.SPEC_DEPTH(50), .TEST_LAT(LAT), .WIDTH(W)) u_spec_loop_launcher_n50 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(ready_w[2]),
    .start_bound(start_bound), .done(done_w[2]), .result(res_w[2]));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // smallest spacing whose window of depth slots reaches the latency
  function automatic int ii_of(input int depth, input int lat);
    if (depth == 0) return lat;
    for (int ii = 1; ii <= lat; ii++) if (depth * ii >= lat) return ii;
    return lat;
  endfunction

  function automatic int exp_lat(input int depth, input int b);
    int ii, tail;
    ii = ii_of(depth, LAT);
    tail = 0;
    while (tail * ii < LAT) tail++;
    return 2 + (b + tail - 1) * ii + LAT;
  endfunction

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check_reset();
    for (int i = 0; i < NI; i++) begin
      chk(done_w[i] == 1'b0, "R10", "done after reset", done_w[i], 0);
      chk(ready_w[i] == 1'b1, "R10", "ready after reset", ready_w[i], 1);
      chk(res_w[i] == '0, "R10", "result after reset", res_w[i], 0);
      prev[i] = res_w[i];
    end
  endtask

  // one job on all three variants; poke offers a second request mid-run
  task automatic run_job(input int b, input bit poke);
    int got [NI];
    int cyc;
    bit all;
    @(negedge clk);
    start_bound = W'(b);
    start_valid = 1'b1;
    for (int i = 0; i < NI; i++) chk(ready_w[i], "R6", "ready before start", ready_w[i], 1);
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    for (int i = 0; i < NI; i++) got[i] = -1;
    cyc = 0;
    all = 1'b0;
    while (!all && cyc < 6000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      start_valid = 1'b0;
      if (poke && cyc == 5) begin
        start_valid = 1'b1;
        start_bound = W'(b + 50);
        for (int i = 0; i < NI; i++) begin
          chk(!ready_w[i], "R6", "ready while busy", ready_w[i], 0);
          chk(res_w[i] == prev[i], "R7", "result held into next job", res_w[i], prev[i]);
        end
      end
      all = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (got[i] >= 0 && cyc == got[i] + 1)
          chk(!done_w[i], "R5", "done pulse width", done_w[i], 0);
        if (done_w[i] && got[i] < 0) got[i] = cyc;
        if (got[i] < 0 || cyc <= got[i]) all = 1'b0;
      end
    end
    for (int i = 0; i < NI; i++) begin
      chk(res_w[i] == W'(b), "R3 R4", $sformatf("result depth %0d", DEPTHS[i]), res_w[i], b);
      chk(got[i] == exp_lat(DEPTHS[i], b), "R1 R8 R9",
          $sformatf("latency depth %0d bound %0d", DEPTHS[i], b), got[i], exp_lat(DEPTHS[i], b));
      prev[i] = res_w[i];
    end
  endtask

  task automatic idle_hold();
    for (int k = 0; k < 25; k++) begin
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
        if (k == 24) begin
          chk(res_w[i] == prev[i], "R7", "result held idle", res_w[i], prev[i]);
          chk(ready_w[i], "R6", "ready when idle", ready_w[i], 1);
        end
        if (done_w[i]) chk(1'b0, "R5", "spurious done", 1, 0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_reset();
    run_job(0, 1'b0);
    run_job(1, 1'b0);
    run_job(13, 1'b0);
    idle_hold();
    run_job(9, 1'b1);
    idle_hold();
    run_job(37, 1'b0);
    summary();
  end
endmodule